// File: doc/BRIEF.md
# Card Status Change Interrupt Logic

This block watches the raw signals of one removable-card socket and turns changes on them into latched, software-visible events. There are six raw inputs: a pair of card-detect lines, a ready line, a battery-warning line, a battery-dead line and a general-purpose input. Each passes through a synchroniser. Edge logic then sets one of five sticky change flags. A host read of the change register returns the flags and clears them. The interrupt output is high while any flag that software has enabled is set.

A small register port selects one of three registers with `sel_i`. Select 0 is the live interface status, select 1 is the change register (cleared by reading it) and select 2 is the enable register. The enable register also carries an IRQ steering field, which is presented on `irq_sel_o` for the routing logic outside this block. Read data is combinational from the selected register. Every signal is a plain control or status pin, because the block carries no data stream.

Top module: `card_status_irq`

## Requirements
- R1: While reset is held, and right after it, the status, change and enable registers all read 0x00, and `irq_o` is low.
- R2: The status register (select 0) shows the synchronised raw levels:
  - bit0 and bit1: the two detect lines.
  - bit2: ready.
  - bit3: battery warning.
  - bit4: battery dead.
  - bit5: general-purpose input.
  - bit6: card present, which is 1 only when both detect lines read 1.
  - bit7: always 0.
- R3: Change-register bit3 (card detect) is set when either detect line changes value in either direction.
- R4: Change-register bit2 (ready) is set only on a 0-to-1 transition of ready. A falling ready sets nothing.
- R5: Any transition sets the corresponding change-register bit: battery dead sets bit0, battery warning sets bit1, and the general-purpose input sets bit4. Bits 7:5 read 0.
- R6: A change flag stays set until the change register is read with `rd_en_i` high. That read returns the flags, and on the next clock edge they clear.
- R7: An event that is detected in the same cycle as a clearing read stays latched and is returned by the next read.
- R8: The enable register (select 2) is written with `wr_en_i` and reads back the value written. Bits 4:0 enable the change flags bit for bit. Bits 7:5 are the IRQ steering field, driven on `irq_sel_o` (field shift 5).
- R9: `irq_o` is high exactly when some change flag is set and its enable bit is set. Writing zero to the enable register therefore disables all change interrupts.
- R10: Raw levels present at reset release do not count as changes. No flag is set until an input actually changes after the synchroniser has filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| det_i | input | 2 | Raw card-detect lines, 1 = contact made |
| ready_i | input | 1 | Raw card ready level |
| bwarn_i | input | 1 | Raw battery-warning level |
| bdead_i | input | 1 | Raw battery-dead level |
| gpi_i | input | 1 | Raw general-purpose input |
| sel_i | input | 2 | Register select: 0 status, 1 change, 2 enable, 3 reads zero |
| rd_en_i | input | 1 | Read strobe; clears the change register when select is 1 |
| wr_en_i | input | 1 | Write strobe for the enable register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (combinational) |
| irq_o | output | 1 | Status-change interrupt |
| irq_sel_o | output | 3 | IRQ steering field from the enable register |

## Verification
The hardest case to reach from the ports is an input edge that arrives at the latch in exactly the cycle in which a clearing read is in progress. To hit it, the stimulus toggles an input, counts the synchroniser and edge stages, and asserts the read two falling edges later. A second flag, latched earlier, shows that the read returned the old flags and not the new one. The start-up mask is reached by holding every input high through reset. Beyond these cases, sweeps cover every raw input pattern in two orders and every pairing of enable mask with a single pending flag.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int NRAW    = 6;
  localparam int NFLAG   = 5;
  localparam int DATA_W  = 8;
  localparam int IRQ_SHIFT = NFLAG;
  localparam int IRQ_W   = DATA_W - IRQ_SHIFT;

  // raw level positions (also status register bits)
  localparam int RAW_DET0  = 0;
  localparam int RAW_DET1  = 1;
  localparam int RAW_RDY   = 2;
  localparam int RAW_BWARN = 3;
  localparam int RAW_BDEAD = 4;
  localparam int RAW_GPI   = 5;
  localparam int STS_PRESENT = 6;

  // change flag positions (also enable bits)
  localparam int FLG_BDEAD = 0;
  localparam int FLG_BWARN = 1;
  localparam int FLG_RDY   = 2;
  localparam int FLG_CD    = 3;
  localparam int FLG_GPI   = 4;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CHANGE = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;
endpackage

// File: rtl/csc_sync.sv
module csc_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) stg[s] <= stg[s-1];
      stg[0] <= d;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/csc_detect.sv
module csc_detect
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NRAW-1:0]  lvl,
  output logic [NFLAG-1:0] ev
);
  // edges are ignored until the synchroniser and the history flop hold real samples
  localparam int WARM = SYNC_STAGES + 1;
  localparam int CW   = $clog2(WARM + 1);

  logic [NRAW-1:0]  prev;
  logic [CW-1:0]    warm_cnt;
  logic             armed;
  logic [NRAW-1:0]  diff;
  logic [NFLAG-1:0] ev_raw;

  assign armed = (warm_cnt == CW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev     <= '0;
      warm_cnt <= '0;
    end else begin
      prev <= lvl;
      if (!armed) warm_cnt <= warm_cnt + 1'b1;
    end
  end

  assign diff = lvl ^ prev;

  always_comb begin
    ev_raw            = '0;
    ev_raw[FLG_CD]    = diff[RAW_DET0] | diff[RAW_DET1];
    ev_raw[FLG_RDY]   = lvl[RAW_RDY] & ~prev[RAW_RDY];
    ev_raw[FLG_BWARN] = diff[RAW_BWARN];
    ev_raw[FLG_BDEAD] = diff[RAW_BDEAD];
    ev_raw[FLG_GPI]   = diff[RAW_GPI];
  end

  assign ev = armed ? ev_raw : '0;
endmodule

// File: rtl/csc_latch.sv
module csc_latch
  import csc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev,
  input  logic             clr,
  output logic [NFLAG-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= ev;          // coincident events survive the clear
    else          flags <= flags | ev;
  end
endmodule

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  sel_e              sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NRAW-1:0]   lvl,
  input  logic [NFLAG-1:0]  flags,
  output logic [DATA_W-1:0] rdata,
  output logic [NFLAG-1:0]  en_mask,
  output logic [IRQ_W-1:0]  irq_sel
);
  logic [DATA_W-1:0] en_q;
  logic              present;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            en_q <= '0;
    else if (wr_en && sel == SEL_ENABLE)   en_q <= wdata;
  end

  assign en_mask = en_q[NFLAG-1:0];
  assign irq_sel = en_q[IRQ_SHIFT +: IRQ_W];
  assign present = lvl[RAW_DET0] & lvl[RAW_DET1];

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_STATUS: begin
        rdata[NRAW-1:0]    = lvl;
        rdata[STS_PRESENT] = present;
      end
      SEL_CHANGE: rdata[NFLAG-1:0] = flags;
      SEL_ENABLE: rdata = en_q;
      SEL_NONE:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/card_status_irq.sv
module card_status_irq
  import csc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        det_i,
  input  logic              ready_i,
  input  logic              bwarn_i,
  input  logic              bdead_i,
  input  logic              gpi_i,
  input  logic [1:0]        sel_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic [IRQ_W-1:0]  irq_sel_o
);
  logic [NRAW-1:0]  raw;
  logic [NRAW-1:0]  lvl;
  logic [NFLAG-1:0] ev;
  logic [NFLAG-1:0] chg_q;
  logic [NFLAG-1:0] en_mask;
  logic             chg_clr;
  sel_e             sel;

  assign raw     = {gpi_i, bdead_i, bwarn_i, ready_i, det_i};
  assign sel     = sel_e'(sel_i);
  assign chg_clr = rd_en_i && (sel == SEL_CHANGE);

  csc_sync #(.W(NRAW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
  );

  csc_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .ev(ev)
  );

  csc_latch u_lat (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(chg_clr), .flags(chg_q)
  );

  csc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en_i), .wdata(wdata_i),
    .lvl(lvl), .flags(chg_q), .rdata(rdata_o), .en_mask(en_mask),
    .irq_sel(irq_sel_o)
  );

  assign irq_o = |(chg_q & en_mask);
endmodule

// File: rtl/csc_checker.sv
module csc_checker
  import csc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        sel_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [NFLAG-1:0]  ev,
  input logic [NFLAG-1:0]  flags,
  input logic [NFLAG-1:0]  en_mask,
  input logic [NRAW-1:0]   lvl,
  input logic              irq_o,
  input logic [IRQ_W-1:0]  irq_sel_o
);
  logic clr_rd;
  assign clr_rd = rd_en_i && (sel_i == 2'd1);

  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && ev == '0) |=> (flags == '0));

  a_r6_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> ((flags & $past(flags)) == $past(flags)));

  a_r7_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> ((flags & $past(ev)) == $past(ev)));

  a_r4_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl[RAW_RDY]) |-> !ev[FLG_RDY]);

  a_r9_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_mask) == '0) |-> !irq_o);

  a_r9_raised_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & en_mask) != '0) |-> irq_o);

  a_r8_steering_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sel_i == 2'd2) |=> (irq_sel_o == $past(wdata_i[DATA_W-1:IRQ_SHIFT])));
endmodule

bind card_status_irq csc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .wdata_i(wdata_i), .ev(ev), .flags(chg_q),
  .en_mask(en_mask), .lvl(lvl), .irq_o(irq_o), .irq_sel_o(irq_sel_o)
);

// File: tb/tb_card_status_irq.sv
module tb_card_status_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] rawv = 6'h00;
  logic [1:0] sel = 2'd0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [2:0] irq_sel;
  int vecs = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  card_status_irq dut (
    .clk(clk), .rst_n(rst_n), .det_i(rawv[1:0]), .ready_i(rawv[2]),
    .bwarn_i(rawv[3]), .bdead_i(rawv[4]), .gpi_i(rawv[5]),
    .sel_i(sel), .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .irq_sel_o(irq_sel)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    sel = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    sel = a; wr_en = 1'b1; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_status(input logic [5:0] v);
    return {1'b0, (v[1:0] == 2'b11), v};
  endfunction

  function automatic logic [7:0] exp_flags(input logic [5:0] pv, input logic [5:0] v);
    logic [5:0] df = pv ^ v;
    return {3'b000, df[5], df[0] | df[1], v[2] & ~pv[2], df[3], df[4]};
  endfunction

  // creates exactly one pending flag f, flags assumed clear on entry
  task automatic make_event(input int f);
    logic [7:0] tmp;
    case (f)
      0: rawv[4] = ~rawv[4];
      1: rawv[3] = ~rawv[3];
      2: begin
        if (rawv[2]) begin
          rawv[2] = 1'b0; settle(); rd(2'd1, tmp);
        end
        rawv[2] = 1'b1;
      end
      3: rawv[0] = ~rawv[0];
      default: rawv[5] = ~rawv[5];
    endcase
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [5:0] pv;
    logic [5:0] v;

    // R1 / R10: inputs high through reset
    rawv = 6'h3F;
    repeat (3) @(negedge clk);
    sel = 2'd0; #1 chk("R1 status in reset", rdata, 8'h00);
    sel = 2'd1; #1 chk("R1 change in reset", rdata, 8'h00);
    sel = 2'd2; #1 chk("R1 enable in reset", rdata, 8'h00);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    sel = 2'd1; #1 chk("R10 no start-up flags", rdata, 8'h00);
    sel = 2'd2; #1 chk("R1 enable after reset", rdata, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
    @(negedge clk);
    rd(2'd0, d); chk("R2 status at start", d, exp_status(6'h3F));

    // R2..R6: sweep all raw patterns, ascending then gray order
    pv = rawv;
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 64; i++) begin
        v = (pass == 0) ? 6'(i) : 6'(i ^ (i >> 1));
        rawv = v;
        settle();
        rd(2'd0, d); chk("R2 live status", d, exp_status(v));
        rd(2'd1, d); chk("R3 R4 R5 R6 change flags", d, exp_flags(pv, v));
        pv = v;
      end
    end
    rd(2'd1, d); chk("R6 cleared after read", d, 8'h00);

    // R4: falling ready ignored
    rawv[2] = 1'b1; settle(); rd(2'd1, d);
    rawv[2] = 1'b0; settle();
    rd(2'd1, d); chk("R4 falling ready sets nothing", d, 8'h00);
    rd(2'd0, d); chk("R4 status ready low", d & 8'h04, 8'h00);

    // R6: flags persist without a read
    rawv[5] = ~rawv[5]; settle();
    repeat (12) @(negedge clk);
    rd(2'd1, d); chk("R6 flag held until read", d, 8'h10);
    rd(2'd1, d); chk("R6 second read empty", d, 8'h00);

    // R7: event coincident with the clearing read
    rawv[3] = ~rawv[3]; settle();        // bwarn latched
    rawv[5] = ~rawv[5];                  // gpi edge reaches latch two edges later
    @(negedge clk); @(negedge clk);
    rd(2'd1, d); chk("R7 read returns old flag", d, 8'h02);
    @(negedge clk);
    rd(2'd1, d); chk("R7 coincident event kept", d, 8'h10);
    rd(2'd1, d); chk("R7 then empty", d, 8'h00);

    // R8: enable register and steering field
    wr(2'd2, 8'hA5);
    rd(2'd2, d); chk("R8 enable readback", d, 8'hA5);
    chk("R8 steering field", {5'b0, irq_sel}, 8'h05);
    wr(2'd1, 8'hFF);
    rd(2'd2, d); chk("R8 write to other select ignored", d, 8'hA5);
    wr(2'd2, 8'h00);

    // R9: every mask against every single pending flag
    for (int f = 0; f < 5; f++) begin
      for (int m = 0; m < 32; m++) begin
        make_event(f);
        chk("R9 idle with enable zero", {7'b0, irq}, 8'h00);
        wr(2'd2, {3'(m), 5'(m)});
        chk("R9 irq vs mask", {7'b0, irq}, {7'b0, m[f]});
        wr(2'd2, 8'h00);
        chk("R9 zero enable disables", {7'b0, irq}, 8'h00);
        rd(2'd1, d); chk("R9 pending flag", d, 8'(1 << f));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule